// File: doc/BRIEF.md
# Transactional Forwarding Line Controller

This block is the state machine that governs one line of a private first-level cache in a multicore system with hardware transactions. Besides ordinary invalid, shared and modified coherence states, the line can hold data that a running transaction has read or written speculatively. When another transaction reads a line that the local transaction has written, the line hands over its speculative value instead of declaring a conflict. The consuming line then remembers which transaction produced the value, so it can follow that producer's later commit, abort or overwrite.

The controller accepts one local request per cycle from its core and one snooped bus event per cycle. It answers with the registered line state, a data-supply enable, a bus message to issue, an abort request for the local transaction and a commit stall. The bus is treated as atomic: a local miss is filled in the same cycle, and the fill flags whether the data came from a speculative producer. The snooped event takes priority. A local request offered in the same cycle is refused through `lcl_accept`, and the core must present it again.

Top module: `txfwd_line_ctrl`

## Requirements
- R1: After reset the line state is invalid (code 0), and fwd_en, msg_valid, abort_req and commit_stall are low. State codes: 0 invalid, 1 shared, 2 modified, 3 tx-read, 4 tx-written, 5 tx-written-over-dirty, 6 tx-written-forwarded, 7 received, 8 received-written, 9 received-written-forwarded, 10 committing. All outputs are registered and appear in the cycle after the request.
- R2: Plain local ops (op codes: 0 load, 1 store, 4 evict) follow ordinary coherence. A load on invalid goes to shared and issues read (kind 0). A store on invalid or shared goes to modified and issues exclusive-read (kind 1). Evicting modified goes to invalid and issues write-back (kind 7). Evicting shared goes to invalid with no message.
- R3: A transactional load (op 2) on invalid issues tx-read (kind 2) and enters tx-read, and on shared it enters tx-read with no message. A transactional store (op 3) on shared or tx-read enters tx-written and issues tx-write (kind 3). A transactional store on modified first writes the line back (kind 7) and enters tx-written-over-dirty. The request's transaction ID becomes the line owner.
- R4: A transactional fill marked as forwarded enters received (after a load) or received-written (after a store), and records the producer's ID given with the fill.
- R5: A snooped tx-read (kind 2) from another transaction on tx-written or tx-written-over-dirty supplies data (fwd_en) and enters tx-written-forwarded. On received-written it supplies data and enters received-written-forwarded.
- R6: A transactional store to a forwarded line issues overwrite (kind 4) carrying the owner ID. Tx-written-forwarded returns to tx-written, and received-written-forwarded returns to received-written.
- R7: A snooped overwrite (kind 4) or tx-abort (kind 5) whose ID equals the recorded producer of a received-class line raises abort_req and leaves the state unchanged. The same message from any other ID has no effect.
- R8: A snooped tx-commit (kind 6) from the recorded producer clears the dependence: received becomes tx-read, received-written becomes tx-written, and received-written-forwarded becomes tx-written-forwarded.
- R9: Local abort (op 5) sends tx-written, tx-written-over-dirty and the received-written states to invalid, and sends tx-read and received to shared. A forwarded line also issues tx-abort (kind 5).
- R10: Local commit (op 6) on a received-class line asserts commit_stall and changes nothing. On tx-read it goes to shared. On the written states it enters committing, and a forwarded line issues tx-commit (kind 6). Retire (op 7) moves committing to modified.
- R11: Evicting a line in any transactional state except committing raises abort_req and keeps the line, with no write-back.
- R12: A snooped event carrying the owner's own ID on a line in a transactional state (codes 3 to 10) has no effect at all.
- R13: When a snoop and a local request arrive together, lcl_accept is low and only the snoop acts.
- R14: A snooped read (kind 0) on modified supplies data and goes to shared. A snooped exclusive-read (kind 1) invalidates a shared line. A non-transactional snooped exclusive-read on a line in a transactional state raises abort_req.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lcl_valid | input | 1 | Local request present |
| lcl_op | input | 3 | Local operation code |
| lcl_txid | input | TXID_W | ID of the local transaction |
| fill_fwd | input | 1 | Atomic fill came from a speculative producer |
| fill_src | input | TXID_W | ID of that producer |
| lcl_accept | output | 1 | Local request taken this cycle |
| snp_valid | input | 1 | Snooped bus event present |
| snp_kind | input | 3 | Snooped event kind |
| snp_txid | input | TXID_W | ID of the transaction behind the snoop |
| line_state | output | 4 | Current line state code |
| fwd_en | output | 1 | Supply line data to the bus |
| msg_valid | output | 1 | Bus message to issue |
| msg_kind | output | 3 | Kind of that message |
| msg_txid | output | TXID_W | ID carried by that message |
| abort_req | output | 1 | Ask the core to abort its transaction |
| commit_stall | output | 1 | Commit refused: dependence still open |

## Verification
The bench targets the ID comparisons. A snoop from the line's own transaction must be ignored, while the same event from a foreign transaction forwards data. A design that compared against the wrong register would either forward to itself or miss real conflicts. Overwrite and abort notices are sent both from the true producer and from an unrelated ID: a controller that skipped the producer match would abort transactions needlessly, and one that never matched would keep stale speculative data. The bench also commits while a dependence is still open, stores to a forwarded line, and sends a snoop and a local request in the same cycle. Wrong handling there would let a consumer commit ahead of its producer, leave readers of a stale value alive, or apply two updates in one cycle.

// File: rtl/txfwd_pkg.sv
package txfwd_pkg;

  typedef enum logic [3:0] {
    ST_INV    = 4'd0,
    ST_SHR    = 4'd1,
    ST_MOD    = 4'd2,
    ST_TRD    = 4'd3,
    ST_TWR    = 4'd4,
    ST_TWRD   = 4'd5,
    ST_TWRF   = 4'd6,
    ST_RCV    = 4'd7,
    ST_RCVW   = 4'd8,
    ST_RCVWF  = 4'd9,
    ST_CMT    = 4'd10
  } line_st_e;

  typedef enum logic [2:0] {
    OP_LD     = 3'd0,
    OP_ST     = 3'd1,
    OP_TLD    = 3'd2,
    OP_TST    = 3'd3,
    OP_EVICT  = 3'd4,
    OP_ABORT  = 3'd5,
    OP_COMMIT = 3'd6,
    OP_RETIRE = 3'd7
  } lcl_op_e;

  typedef enum logic [2:0] {
    BK_RD     = 3'd0,
    BK_RDX    = 3'd1,
    BK_TRD    = 3'd2,
    BK_TWR    = 3'd3,
    BK_OVW    = 3'd4,
    BK_TABORT = 3'd5,
    BK_TCMT   = 3'd6,
    BK_WB     = 3'd7
  } bus_kind_e;

  typedef struct packed {
    line_st_e  nxt;
    logic      msg_v;
    bus_kind_e msg_k;
    logic      fwd;
    logic      abort;
    logic      stall;
    logic      load_owner;
    logic      load_src;
  } line_act_t;

  function automatic logic is_tx_state(line_st_e s);
    return (s != ST_INV) && (s != ST_SHR) && (s != ST_MOD);
  endfunction

endpackage

// File: rtl/txfwd_rst_sync.sv
module txfwd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[LAST];
endmodule

// File: rtl/txfwd_local_dec.sv
module txfwd_local_dec
  import txfwd_pkg::*;
(
  input  line_st_e  st,
  input  lcl_op_e   op,
  input  logic      fill_fwd,
  output line_act_t act
);
  always_comb begin
    act     = '0;
    act.nxt = st;
    unique case (op)
      OP_LD: begin
        if (st == ST_INV) begin
          act.nxt   = ST_SHR;
          act.msg_v = 1'b1;
          act.msg_k = BK_RD;
        end
      end
      OP_ST: begin
        if (st == ST_INV || st == ST_SHR) begin
          act.nxt   = ST_MOD;
          act.msg_v = 1'b1;
          act.msg_k = BK_RDX;
        end
      end
      OP_TLD: begin
        case (st)
          ST_INV: begin
            act.nxt        = fill_fwd ? ST_RCV : ST_TRD;
            act.msg_v      = 1'b1;
            act.msg_k      = BK_TRD;
            act.load_owner = 1'b1;
            act.load_src   = fill_fwd;
          end
          ST_SHR: begin
            act.nxt        = ST_TRD;
            act.load_owner = 1'b1;
          end
          ST_MOD: begin
            act.nxt        = ST_TRD;
            act.msg_v      = 1'b1;
            act.msg_k      = BK_WB;
            act.load_owner = 1'b1;
          end
          default: ;
        endcase
      end
      OP_TST: begin
        case (st)
          ST_INV: begin
            act.nxt        = fill_fwd ? ST_RCVW : ST_TWR;
            act.msg_v      = 1'b1;
            act.msg_k      = BK_TWR;
            act.load_owner = 1'b1;
            act.load_src   = fill_fwd;
          end
          ST_SHR: begin
            act.nxt        = ST_TWR;
            act.msg_v      = 1'b1;
            act.msg_k      = BK_TWR;
            act.load_owner = 1'b1;
          end
          ST_MOD: begin
            act.nxt        = ST_TWRD;
            act.msg_v      = 1'b1;
            act.msg_k      = BK_WB;
            act.load_owner = 1'b1;
          end
          ST_TRD: begin
            act.nxt   = ST_TWR;
            act.msg_v = 1'b1;
            act.msg_k = BK_TWR;
          end
          ST_RCV: begin
            act.nxt   = ST_RCVW;
            act.msg_v = 1'b1;
            act.msg_k = BK_TWR;
          end
          ST_TWRF: begin
            act.nxt   = ST_TWR;
            act.msg_v = 1'b1;
            act.msg_k = BK_OVW;
          end
          ST_RCVWF: begin
            act.nxt   = ST_RCVW;
            act.msg_v = 1'b1;
            act.msg_k = BK_OVW;
          end
          default: ;
        endcase
      end
      OP_EVICT: begin
        case (st)
          ST_MOD: begin
            act.nxt   = ST_INV;
            act.msg_v = 1'b1;
            act.msg_k = BK_WB;
          end
          ST_SHR:          act.nxt   = ST_INV;
          ST_INV, ST_CMT:  ;
          default:         act.abort = 1'b1;
        endcase
      end
      OP_ABORT: begin
        case (st)
          ST_TWR, ST_TWRD, ST_RCVW: act.nxt = ST_INV;
          ST_TWRF, ST_RCVWF: begin
            act.nxt   = ST_INV;
            act.msg_v = 1'b1;
            act.msg_k = BK_TABORT;
          end
          ST_TRD, ST_RCV: act.nxt = ST_SHR;
          default: ;
        endcase
      end
      OP_COMMIT: begin
        case (st)
          ST_RCV, ST_RCVW, ST_RCVWF: act.stall = 1'b1;
          ST_TWR, ST_TWRD:           act.nxt   = ST_CMT;
          ST_TWRF: begin
            act.nxt   = ST_CMT;
            act.msg_v = 1'b1;
            act.msg_k = BK_TCMT;
          end
          ST_TRD:  act.nxt = ST_SHR;
          default: ;
        endcase
      end
      OP_RETIRE: begin
        if (st == ST_CMT) act.nxt = ST_MOD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/txfwd_snoop_dec.sv
module txfwd_snoop_dec
  import txfwd_pkg::*;
#(
  parameter int TXID_W = 4
) (
  input  line_st_e          st,
  input  bus_kind_e         kind,
  input  logic [TXID_W-1:0] snp_txid,
  input  logic [TXID_W-1:0] owner,
  input  logic [TXID_W-1:0] src,
  output line_act_t         act
);
  logic own_msg;
  logic from_src;
  logic nontx_any;
  logic src_kill;

  assign own_msg   = is_tx_state(st) && (snp_txid == owner);
  assign from_src  = (snp_txid == src);
  assign nontx_any = (kind == BK_RD) || (kind == BK_RDX);
  assign src_kill  = from_src && ((kind == BK_OVW) || (kind == BK_TABORT));

  always_comb begin
    act     = '0;
    act.nxt = st;
    if (!own_msg) begin
      case (st)
        ST_SHR: begin
          if (kind == BK_RDX || kind == BK_TWR) act.nxt = ST_INV;
        end
        ST_MOD: begin
          if (kind == BK_RD || kind == BK_TRD) begin
            act.nxt = ST_SHR;
            act.fwd = 1'b1;
          end else if (kind == BK_RDX || kind == BK_TWR) begin
            act.nxt = ST_INV;
            act.fwd = 1'b1;
          end
        end
        ST_TRD: begin
          if (kind == BK_RDX) act.abort = 1'b1;
        end
        ST_TWR, ST_TWRD: begin
          if (kind == BK_TRD) begin
            act.nxt = ST_TWRF;
            act.fwd = 1'b1;
          end else if (nontx_any) begin
            act.abort = 1'b1;
          end
        end
        ST_TWRF: begin
          if (kind == BK_TRD)  act.fwd   = 1'b1;
          else if (nontx_any)  act.abort = 1'b1;
        end
        ST_RCV: begin
          if (kind == BK_RDX || src_kill)            act.abort = 1'b1;
          else if (kind == BK_TCMT && from_src)      act.nxt   = ST_TRD;
        end
        ST_RCVW: begin
          if (kind == BK_TRD) begin
            act.nxt = ST_RCVWF;
            act.fwd = 1'b1;
          end else if (nontx_any || src_kill) begin
            act.abort = 1'b1;
          end else if (kind == BK_TCMT && from_src) begin
            act.nxt = ST_TWR;
          end
        end
        ST_RCVWF: begin
          if (kind == BK_TRD)                        act.fwd   = 1'b1;
          else if (nontx_any || src_kill)            act.abort = 1'b1;
          else if (kind == BK_TCMT && from_src)      act.nxt   = ST_TWRF;
        end
        ST_CMT: begin
          if (kind == BK_RD || kind == BK_TRD) act.fwd = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txfwd_line_ctrl.sv
module txfwd_line_ctrl
  import txfwd_pkg::*;
#(
  parameter int TXID_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcl_valid,
  input  logic [2:0]        lcl_op,
  input  logic [TXID_W-1:0] lcl_txid,
  input  logic              fill_fwd,
  input  logic [TXID_W-1:0] fill_src,
  output logic              lcl_accept,
  input  logic              snp_valid,
  input  logic [2:0]        snp_kind,
  input  logic [TXID_W-1:0] snp_txid,
  output logic [3:0]        line_state,
  output logic              fwd_en,
  output logic              msg_valid,
  output logic [2:0]        msg_kind,
  output logic [TXID_W-1:0] msg_txid,
  output logic              abort_req,
  output logic              commit_stall
);
  logic              rst_n_s;
  line_st_e          state_q;
  logic [TXID_W-1:0] owner_q;
  logic [TXID_W-1:0] src_q;
  line_act_t         lcl_act;
  line_act_t         snp_act;
  line_act_t         act;
  logic              take_lcl;
  logic              upd_en;
  logic [TXID_W-1:0] msg_txid_d;

  logic              fwd_q;
  logic              msg_v_q;
  bus_kind_e         msg_k_q;
  logic [TXID_W-1:0] msg_txid_q;
  logic              abort_q;
  logic              stall_q;

  txfwd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  txfwd_local_dec u_local_dec (
    .st       (state_q),
    .op       (lcl_op_e'(lcl_op)),
    .fill_fwd (fill_fwd),
    .act      (lcl_act)
  );

  txfwd_snoop_dec #(.TXID_W(TXID_W)) u_snoop_dec (
    .st       (state_q),
    .kind     (bus_kind_e'(snp_kind)),
    .snp_txid (snp_txid),
    .owner    (owner_q),
    .src      (src_q),
    .act      (snp_act)
  );

  // snoop wins the cycle; a colliding local request is refused
  assign take_lcl   = lcl_valid && !snp_valid;
  assign lcl_accept = take_lcl;
  assign upd_en     = snp_valid || lcl_valid;

  always_comb begin
    if (snp_valid)     act = snp_act;
    else if (take_lcl) act = lcl_act;
    else begin
      act     = '0;
      act.nxt = state_q;
    end
  end

  always_comb begin
    if (lcl_act.load_owner)      msg_txid_d = lcl_txid;
    else if (is_tx_state(state_q)) msg_txid_d = owner_q;
    else                         msg_txid_d = lcl_txid;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_INV;
      owner_q <= '0;
      src_q   <= '0;
    end else if (upd_en) begin
      state_q <= act.nxt;
      if (take_lcl && lcl_act.load_owner) owner_q <= lcl_txid;
      if (take_lcl && lcl_act.load_src)   src_q   <= fill_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      fwd_q      <= 1'b0;
      msg_v_q    <= 1'b0;
      msg_k_q    <= BK_RD;
      msg_txid_q <= '0;
      abort_q    <= 1'b0;
      stall_q    <= 1'b0;
    end else begin
      fwd_q      <= act.fwd;
      msg_v_q    <= act.msg_v;
      msg_k_q    <= act.msg_k;
      msg_txid_q <= act.msg_v ? msg_txid_d : '0;
      abort_q    <= act.abort;
      stall_q    <= act.stall;
    end
  end

  assign line_state   = state_q;
  assign fwd_en       = fwd_q;
  assign msg_valid    = msg_v_q;
  assign msg_kind     = msg_k_q;
  assign msg_txid     = msg_txid_q;
  assign abort_req    = abort_q;
  assign commit_stall = stall_q;
endmodule

// File: rtl/txfwd_line_ctrl_chk.sv
module txfwd_line_ctrl_chk #(
  parameter int TXID_W = 4
) (
  input logic              clk,
  input logic              rst_ni,
  input logic [3:0]        st,
  input logic [TXID_W-1:0] owner,
  input logic              lcl_valid,
  input logic [2:0]        lcl_op,
  input logic              snp_valid,
  input logic [TXID_W-1:0] snp_txid,
  input logic              fwd,
  input logic              abort,
  input logic              msg_v,
  input logic [2:0]        msg_k
);
  logic in_tx;
  assign in_tx = (st >= 4'd3) && (st <= 4'd10);

  // R12: own-ID snoops leave the line untouched
  a_r12_own_snoop_ignored: assert property (@(posedge clk) disable iff (!rst_ni)
    (snp_valid && in_tx && snp_txid == owner) |=> (st == $past(st) && !fwd && !abort));

  // R7 / R11: an abort request never comes with a state change
  a_r7_abort_keeps_state: assert property (@(posedge clk) disable iff (!rst_ni)
    abort |-> (st == $past(st)));

  // R5 / R14: data is supplied only from a line holding a dirty copy
  a_r5_fwd_from_dirty: assert property (@(posedge clk) disable iff (!rst_ni)
    fwd |-> ($past(st) inside {4'd2, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10}));

  // R6: overwrite notices come only from forwarded lines
  a_r6_ovw_from_forwarded: assert property (@(posedge clk) disable iff (!rst_ni)
    (msg_v && msg_k == 3'd4) |-> ($past(st) inside {4'd6, 4'd9}));

  // R9: after a local abort no speculative line state remains
  a_r9_abort_clears_spec: assert property (@(posedge clk) disable iff (!rst_ni)
    (lcl_valid && !snp_valid && lcl_op == 3'd5) |=> (st inside {4'd0, 4'd1, 4'd2, 4'd10}));

  // R10: a committing line only waits or retires to modified
  a_r10_cmt_exit: assert property (@(posedge clk) disable iff (!rst_ni)
    (st == 4'd10) |=> (st == 4'd10 || st == 4'd2));
endmodule

bind txfwd_line_ctrl txfwd_line_ctrl_chk #(.TXID_W(TXID_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_n_s),
  .st        (line_state),
  .owner     (owner_q),
  .lcl_valid (lcl_valid),
  .lcl_op    (lcl_op),
  .snp_valid (snp_valid),
  .snp_txid  (snp_txid),
  .fwd       (fwd_en),
  .abort     (abort_req),
  .msg_v     (msg_valid),
  .msg_k     (msg_kind)
);

// File: tb/txfwd_line_ctrl_bench.sv
module txfwd_line_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lcl_valid, fill_fwd, snp_valid;
  logic [2:0] lcl_op, snp_kind;
  logic [3:0] lcl_txid, fill_src, snp_txid;
  logic       lcl_accept, fwd_en, msg_valid, abort_req, commit_stall;
  logic [3:0] line_state, msg_txid;
  logic [2:0] msg_kind;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txfwd_line_ctrl u_txfwd_line_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lcl_valid(lcl_valid), .lcl_op(lcl_op), .lcl_txid(lcl_txid),
    .fill_fwd(fill_fwd), .fill_src(fill_src), .lcl_accept(lcl_accept),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_txid(snp_txid),
    .line_state(line_state), .fwd_en(fwd_en), .msg_valid(msg_valid),
    .msg_kind(msg_kind), .msg_txid(msg_txid), .abort_req(abort_req),
    .commit_stall(commit_stall)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // packed view {state, msg_v, msg_k, fwd, abort, stall}
  task automatic chk_out(string tag, int st, int mv, int mk, int fw, int ab, int sl);
    int a, e;
    a = {line_state, msg_valid, msg_kind, fwd_en, abort_req, commit_stall};
    e = {st[3:0], mv[0], mk[2:0], fw[0], ab[0], sl[0]};
    chk(tag, a, e);
  endtask

  // all drivers start and end at a falling edge
  task automatic lcl(int op, int tx, int ff = 0, int fs = 0);
    lcl_valid = 1'b1; lcl_op = op[2:0]; lcl_txid = tx[3:0];
    fill_fwd = ff[0]; fill_src = fs[3:0];
    @(negedge clk);
    lcl_valid = 1'b0; fill_fwd = 1'b0;
  endtask

  task automatic snp(int k, int tx);
    snp_valid = 1'b1; snp_kind = k[2:0]; snp_txid = tx[3:0];
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    lcl_valid = 0; snp_valid = 0; fill_fwd = 0;
    lcl_op = 0; snp_kind = 0; lcl_txid = 0; fill_src = 0; snp_txid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_out("R1 reset outputs", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_msi;
    lcl(0, 0);  chk_out("R2 load miss", 1, 1, 0, 0, 0, 0);
    lcl(1, 0);  chk_out("R2 store upgrade", 2, 1, 1, 0, 0, 0);
    lcl(4, 0);  chk_out("R2 evict dirty", 0, 1, 7, 0, 0, 0);
    lcl(1, 0);  chk_out("R2 store miss", 2, 1, 1, 0, 0, 0);
    snp(0, 3);  chk_out("R14 snoop read on modified", 1, 0, 0, 1, 0, 0);
    snp(1, 3);  chk_out("R14 snoop excl on shared", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_tx_forward;
    lcl(2, 5);  chk_out("R3 tx load miss", 3, 1, 2, 0, 0, 0);
    chk("R3 msg id", msg_txid, 5);
    lcl(3, 5);  chk_out("R3 tx store on tx-read", 4, 1, 3, 0, 0, 0);
    snp(2, 9);  chk_out("R5 forward to foreign reader", 6, 0, 0, 1, 0, 0);
    snp(2, 5);  chk_out("R12 own snoop ignored", 6, 0, 0, 0, 0, 0);
    lcl(3, 5);  chk_out("R6 overwrite of forwarded", 4, 1, 4, 0, 0, 0);
    chk("R6 overwrite id", msg_txid, 5);
    snp(2, 9);  chk_out("R5 forward again", 6, 0, 0, 1, 0, 0);
    lcl(6, 5);  chk_out("R10 commit forwarded", 10, 1, 6, 0, 0, 0);
    lcl(7, 5);  chk_out("R10 retire", 2, 0, 0, 0, 0, 0);
  endtask

  task automatic t_received;
    lcl(4, 0);  chk_out("R2 evict before recv", 0, 1, 7, 0, 0, 0);
    lcl(2, 3, 1, 7); chk_out("R4 forwarded fill on load", 7, 1, 2, 0, 0, 0);
    snp(4, 8);  chk_out("R7 overwrite from stranger", 7, 0, 0, 0, 0, 0);
    snp(4, 7);  chk_out("R7 overwrite from producer", 7, 0, 0, 0, 1, 0);
    lcl(6, 3);  chk_out("R10 commit stalls on dependence", 7, 0, 0, 0, 0, 1);
    snp(6, 7);  chk_out("R8 producer commit", 3, 0, 0, 0, 0, 0);
    lcl(5, 3);  chk_out("R9 abort tx-read", 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_received_written;
    lcl(4, 0);  chk_out("R2 evict shared", 0, 0, 0, 0, 0, 0);
    lcl(3, 4, 1, 2); chk_out("R4 forwarded fill on store", 8, 1, 3, 0, 0, 0);
    snp(2, 6);  chk_out("R5 forward from received-written", 9, 0, 0, 1, 0, 0);
    lcl(3, 4);  chk_out("R6 overwrite received-forwarded", 8, 1, 4, 0, 0, 0);
    chk("R6 overwrite id", msg_txid, 4);
    snp(2, 6);  chk_out("R5 forward again", 9, 0, 0, 1, 0, 0);
    snp(5, 2);  chk_out("R7 producer abort", 9, 0, 0, 0, 1, 0);
    snp(6, 2);  chk_out("R8 producer commit", 6, 0, 0, 0, 0, 0);
    lcl(5, 4);  chk_out("R9 abort forwarded", 0, 1, 5, 0, 0, 0);
  endtask

  task automatic t_dirty;
    lcl(1, 0);  chk_out("R2 store miss", 2, 1, 1, 0, 0, 0);
    lcl(3, 1);  chk_out("R3 tx store over dirty", 5, 1, 7, 0, 0, 0);
    lcl(4, 1);  chk_out("R11 evict tx line", 5, 0, 0, 0, 1, 0);
    snp(1, 0);  chk_out("R14 nontx write on tx line", 5, 0, 0, 0, 1, 0);
    lcl(5, 1);  chk_out("R9 abort dirty tx line", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_shared_read;
    lcl(0, 0);  chk_out("R2 load miss", 1, 1, 0, 0, 0, 0);
    lcl(2, 2);  chk_out("R3 tx load on shared", 3, 0, 0, 0, 0, 0);
    snp(1, 0);  chk_out("R14 nontx write on tx-read", 3, 0, 0, 0, 1, 0);
    lcl(6, 2);  chk_out("R10 commit tx-read", 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_priority;
    lcl_valid = 1'b1; lcl_op = 3'd1; lcl_txid = 0;
    snp_valid = 1'b1; snp_kind = 3'd1; snp_txid = 0;
    #1;
    chk("R13 local refused", lcl_accept, 0);
    @(negedge clk);
    lcl_valid = 1'b0; snp_valid = 1'b0;
    chk_out("R13 snoop only", 0, 0, 0, 0, 0, 0);
    lcl(0, 0);
    chk("R13 local accepted alone", line_state, 1);
  endtask

  initial begin
    t_reset();
    t_msi();
    t_tx_forward();
    t_received();
    t_received_written();
    t_dirty();
    t_shared_read();
    t_priority();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule